// File: doc/BRIEF.md
# Per-Warp Reduced Dependency Scoreboard

This block decides which buffered instructions of a multithreaded SIMT core are free of register hazards. A full scoreboard would keep one bit for every vector register of every warp. This block does not. Each warp has a small table of destination registers whose writes are still in flight. Next to every instruction-buffer slot it keeps a short dependency vector, with one bit for each table entry that the instruction waits on.

When decode places an instruction into a buffer slot, the block compares its sources and its destination with the warp's table. The matching entries become the slot's dependency bits. When the scheduler dispatches a slot, the block frees that slot and records the instruction's destination in a free table entry. When a result is written back, the block releases the table entry holding that register. It also clears the bit for that entry in every slot of the same warp, so results may complete in any order. A slot is offered to the scheduler only when it has no dependency bits set and, if it writes a register, its warp still has a free table entry.

Top module: `sb_warp_scoreboard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every bit of `ready` is 0.
- R2: An instruction inserted with no source or destination that matches a pending write of its warp shows `ready` high after the next clock edge. It stays high until it is dispatched or overwritten. The ready bit of warp w, slot s is bit w*SLOTS+s.
- R3: Read-after-write: if a valid source register equals a pending destination of the same warp, the inserted instruction is not ready.
- R4: Write-after-write: if the valid destination equals a pending destination of the same warp, the inserted instruction is not ready.
- R5: A writeback of register r for warp w releases the pending entry for r. It clears the matching dependency bit in every slot of warp w, so those slots become ready one edge after the writeback if nothing else blocks them.
- R6: Dispatching a slot empties it, so its ready bit is low after the edge. A valid destination of the dispatched instruction becomes a pending write of its warp. The scheduler only dispatches slots whose ready bit is high.
- R7: When all TRACK entries of a warp are pending, an instruction with a valid destination is not ready. An instruction without a destination is unaffected. A writeback that frees an entry makes the first kind ready again.
- R8: A writeback and a dispatch on the same warp in the same cycle both take effect.
- R9: An insert in the same cycle as a dispatch or writeback on the same warp is compared with the table as it stands after those operations. It depends on the register just dispatched, and it does not depend on the register just written back.
- R10: Register 0 is tracked and compared like any other register.
- R11: An instruction whose destination-valid flag is low takes no table entry when it is dispatched.
- R12: Warps are independent. A pending write in one warp never blocks another warp, and a writeback to one warp never clears the dependencies of another.
- R13: Writebacks may arrive in any order. Releasing a later pending register leaves an earlier one pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert a decoded instruction into a buffer slot |
| ins_warp | input | $clog2(NUM_WARPS) | Warp of the inserted instruction |
| ins_slot | input | $clog2(SLOTS) | Buffer slot within that warp |
| ins_srca | input | $clog2(NUM_REGS) | First source register |
| ins_srca_en | input | 1 | First source is used |
| ins_srcb | input | $clog2(NUM_REGS) | Second source register |
| ins_srcb_en | input | 1 | Second source is used |
| ins_dst | input | $clog2(NUM_REGS) | Destination register |
| ins_dst_en | input | 1 | Instruction writes a register |
| disp_valid | input | 1 | Scheduler dispatches a slot |
| disp_warp | input | $clog2(NUM_WARPS) | Warp of the dispatched slot |
| disp_slot | input | $clog2(SLOTS) | Dispatched slot |
| wb_valid | input | 1 | A result is written back |
| wb_warp | input | $clog2(NUM_WARPS) | Warp of the writeback |
| wb_reg | input | $clog2(NUM_REGS) | Register written back |
| ready | output | NUM_WARPS*SLOTS | Slot is hazard-free and may be dispatched |

## Verification
Every operation reaches `ready` through exactly one register stage. An insert, a dispatch or a writeback that is applied at a clock edge is visible on `ready` after that same edge, and `ready` has no combinational path from any input. The bench therefore drives each operation just after an edge and removes it one edge later. It samples `ready` 1 ns after that edge, before the next operation is driven. Same-cycle cases drive two operations in one window and check the combined result at the following sample point.

// File: rtl/sb_pkg.sv
// Package sb_pkg
// Shared constants and helpers for the warp scoreboard.
// Assumes no instance tracks more than SB_MAX_TRACK entries per warp.
package sb_pkg;
    localparam int SB_MAX_TRACK = 32;

    // Keep only the lowest set bit of a vector.
    function automatic logic [SB_MAX_TRACK-1:0] sb_lowest(input logic [SB_MAX_TRACK-1:0] v);
        return v & (~v + 1'b1);
    endfunction
endpackage

// File: rtl/sb_track_table.sv
// Module sb_track_table
// Table of destination registers with writes outstanding, for one warp.
// Allocation picks the lowest entry that is free in the current state.
// An entry released in a cycle is therefore not reused until the next cycle.
// Assumes a register is pending in at most one entry, which the WAW check ensures.
module sb_track_table
    import sb_pkg::*;
#(
    parameter int TRACK = 6,
    parameter int RW    = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       alloc_en,
    input  logic [RW-1:0]              alloc_reg,
    input  logic                       rel_en,
    input  logic [RW-1:0]              rel_reg,
    output logic                       full,
    output logic [TRACK-1:0]           rel_hit,
    output logic [TRACK-1:0]           nxt_v,
    output logic [TRACK-1:0][RW-1:0]   nxt_r
);
    logic [TRACK-1:0]         ent_v;
    logic [TRACK-1:0][RW-1:0] ent_r;
    logic [SB_MAX_TRACK-1:0]  free_ext;
    logic [SB_MAX_TRACK-1:0]  pick;
    logic [TRACK-1:0]         alloc_oh;

    assign full = &ent_v;

    // Choose the lowest free entry for a new allocation.
    always_comb begin
        free_ext = '0;
        free_ext[TRACK-1:0] = ~ent_v;
        pick = sb_lowest(free_ext);
        alloc_oh = alloc_en ? pick[TRACK-1:0] : '0;
    end

    // Find the entry being released and form the next table state.
    always_comb begin
        for (int i = 0; i < TRACK; i++) begin
            rel_hit[i] = rel_en && ent_v[i] && (ent_r[i] == rel_reg);
            nxt_v[i]   = (ent_v[i] && !rel_hit[i]) || alloc_oh[i];
            nxt_r[i]   = alloc_oh[i] ? alloc_reg : ent_r[i];
        end
    end

    // Register the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v <= '0;
            ent_r <= '0;
        end else begin
            ent_v <= nxt_v;
            ent_r <= nxt_r;
        end
    end
endmodule

// File: rtl/sb_dep_lookup.sv
// Module sb_dep_lookup
// Compares an instruction's two sources (RAW) and its destination (WAW)
// with a warp's table and returns one bit per matching valid entry.
// Assumes the table it is given already includes this cycle's updates.
module sb_dep_lookup #(
    parameter int TRACK = 6,
    parameter int RW    = 7
) (
    input  logic [TRACK-1:0]         tv,
    input  logic [TRACK-1:0][RW-1:0] tr,
    input  logic [RW-1:0]            srca,
    input  logic                     srca_en,
    input  logic [RW-1:0]            srcb,
    input  logic                     srcb_en,
    input  logic [RW-1:0]            dst,
    input  logic                     dst_en,
    output logic [TRACK-1:0]         dep
);
    // Mark each valid entry that matches a used operand.
    always_comb begin
        for (int i = 0; i < TRACK; i++) begin
            dep[i] = tv[i] && ((srca_en && tr[i] == srca) ||
                               (srcb_en && tr[i] == srcb) ||
                               (dst_en  && tr[i] == dst));
        end
    end
endmodule

// File: rtl/sb_ibuf_slot.sv
// Module sb_ibuf_slot
// Scoreboard state of one instruction-buffer slot: a valid flag, the
// destination, and the dependency vector that writebacks clear.
// Assumes a load applies to an empty slot or to one dispatched in the same cycle.
module sb_ibuf_slot #(
    parameter int TRACK = 6,
    parameter int RW    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TRACK-1:0] load_dep,
    input  logic [RW-1:0]    load_dst,
    input  logic             load_dst_en,
    input  logic             take,
    input  logic [TRACK-1:0] clr_mask,
    output logic             vld,
    output logic [TRACK-1:0] dep,
    output logic [RW-1:0]    dst,
    output logic             dst_en
);
    // Load, empty, or clear bits of the slot's dependency vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            dep    <= '0;
            dst    <= '0;
            dst_en <= 1'b0;
        end else if (load) begin
            vld    <= 1'b1;
            dep    <= load_dep;
            dst    <= load_dst;
            dst_en <= load_dst_en;
        end else if (take) begin
            vld    <= 1'b0;
            dep    <= '0;
            dst_en <= 1'b0;
        end else begin
            dep    <= dep & ~clr_mask;
        end
    end
endmodule

// File: rtl/sb_warp_scoreboard.sv
// Module sb_warp_scoreboard
// Reduced dependency scoreboard for all warps of a SIMT core. It keeps a
// pending-write table per warp and a dependency vector per buffer slot,
// and reports which slots are free of hazards.
// Assumes: dispatch only of ready slots, inserts only into empty slots or into
// the slot dispatched in the same cycle, NUM_WARPS and SLOTS of at least 2.
module sb_warp_scoreboard #(
    parameter int NUM_WARPS = 8,
    parameter int NUM_REGS  = 128,
    parameter int TRACK     = 6,
    parameter int SLOTS     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ins_valid,
    input  logic [$clog2(NUM_WARPS)-1:0]  ins_warp,
    input  logic [$clog2(SLOTS)-1:0]      ins_slot,
    input  logic [$clog2(NUM_REGS)-1:0]   ins_srca,
    input  logic                          ins_srca_en,
    input  logic [$clog2(NUM_REGS)-1:0]   ins_srcb,
    input  logic                          ins_srcb_en,
    input  logic [$clog2(NUM_REGS)-1:0]   ins_dst,
    input  logic                          ins_dst_en,
    input  logic                          disp_valid,
    input  logic [$clog2(NUM_WARPS)-1:0]  disp_warp,
    input  logic [$clog2(SLOTS)-1:0]      disp_slot,
    input  logic                          wb_valid,
    input  logic [$clog2(NUM_WARPS)-1:0]  wb_warp,
    input  logic [$clog2(NUM_REGS)-1:0]   wb_reg,
    output logic [NUM_WARPS*SLOTS-1:0]    ready
);
    localparam int WW = $clog2(NUM_WARPS);
    localparam int SW = $clog2(SLOTS);
    localparam int RW = $clog2(NUM_REGS);
    localparam int NE = NUM_WARPS * SLOTS;

    logic [NUM_WARPS-1:0]                   w_full;
    logic [NUM_WARPS-1:0][TRACK-1:0]        w_rel;
    logic [NUM_WARPS-1:0][TRACK-1:0]        w_nv;
    logic [NUM_WARPS-1:0][TRACK-1:0][RW-1:0] w_nr;
    logic [NE-1:0]                          s_vld;
    logic [NE-1:0]                          s_dst_en;
    logic [NE-1:0][RW-1:0]                  s_dst;
    logic [NE-1:0][TRACK-1:0]               s_dep;
    logic [TRACK-1:0]                       ins_tv;
    logic [TRACK-1:0][RW-1:0]               ins_tr;
    logic [TRACK-1:0]                       ins_dep;

    // Select the inserting warp's next-state table for the lookup.
    always_comb begin
        ins_tv = '0;
        ins_tr = '0;
        for (int w = 0; w < NUM_WARPS; w++) begin
            if (ins_warp == WW'(w)) begin
                ins_tv = w_nv[w];
                ins_tr = w_nr[w];
            end
        end
    end

    sb_dep_lookup #(.TRACK(TRACK), .RW(RW)) u_lookup (
        .tv(ins_tv), .tr(ins_tr),
        .srca(ins_srca), .srca_en(ins_srca_en),
        .srcb(ins_srcb), .srcb_en(ins_srcb_en),
        .dst(ins_dst), .dst_en(ins_dst_en),
        .dep(ins_dep)
    );

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        logic          disp_here;
        logic          alloc_en;
        logic [RW-1:0] alloc_reg;

        assign disp_here = disp_valid && (disp_warp == WW'(w));

        // Fetch the destination of this warp's dispatched slot.
        always_comb begin
            alloc_en  = 1'b0;
            alloc_reg = '0;
            for (int s = 0; s < SLOTS; s++) begin
                if (disp_here && disp_slot == SW'(s)) begin
                    alloc_en  = s_dst_en[w*SLOTS+s];
                    alloc_reg = s_dst[w*SLOTS+s];
                end
            end
        end

        sb_track_table #(.TRACK(TRACK), .RW(RW)) u_table (
            .clk(clk), .rst_n(rst_n),
            .alloc_en(alloc_en), .alloc_reg(alloc_reg),
            .rel_en(wb_valid && (wb_warp == WW'(w))), .rel_reg(wb_reg),
            .full(w_full[w]), .rel_hit(w_rel[w]),
            .nxt_v(w_nv[w]), .nxt_r(w_nr[w])
        );

        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            localparam int E = w*SLOTS + s;

            sb_ibuf_slot #(.TRACK(TRACK), .RW(RW)) u_slot (
                .clk(clk), .rst_n(rst_n),
                .load(ins_valid && ins_warp == WW'(w) && ins_slot == SW'(s)),
                .load_dep(ins_dep), .load_dst(ins_dst), .load_dst_en(ins_dst_en),
                .take(disp_here && disp_slot == SW'(s)),
                .clr_mask(w_rel[w]),
                .vld(s_vld[E]), .dep(s_dep[E]),
                .dst(s_dst[E]), .dst_en(s_dst_en[E])
            );

            // A slot is ready when nothing blocks it and an entry is free for its destination.
            assign ready[E] = s_vld[E] && (s_dep[E] == '0) && !(s_dst_en[E] && w_full[w]);
        end
    end
endmodule

// File: rtl/sb_warp_scoreboard_chk.sv
// Module sb_warp_scoreboard_chk
// Port-level properties of the scoreboard, attached to every instance by bind.
// Assumes the same parameters as the bound instance.
module sb_warp_scoreboard_chk #(
    parameter int NUM_WARPS = 8,
    parameter int NUM_REGS  = 128,
    parameter int TRACK     = 6,
    parameter int SLOTS     = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          ins_valid,
    input logic [$clog2(NUM_WARPS)-1:0]  ins_warp,
    input logic [$clog2(SLOTS)-1:0]      ins_slot,
    input logic                          disp_valid,
    input logic [$clog2(NUM_WARPS)-1:0]  disp_warp,
    input logic [$clog2(SLOTS)-1:0]      disp_slot,
    input logic                          wb_valid,
    input logic [$clog2(NUM_WARPS)-1:0]  wb_warp,
    input logic [NUM_WARPS*SLOTS-1:0]    ready
);
    localparam int WW = $clog2(NUM_WARPS);
    localparam int SW = $clog2(SLOTS);

    // R1: nothing is ready on the first cycle out of reset.
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ready == '0));

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_w
        for (genvar s = 0; s < SLOTS; s++) begin : g_s
            localparam int E = w*SLOTS + s;
            logic ins_e, disp_e, wb_w, disp_w;
            assign ins_e  = ins_valid && ins_warp == WW'(w) && ins_slot == SW'(s);
            assign disp_e = disp_valid && disp_warp == WW'(w) && disp_slot == SW'(s);
            assign wb_w   = wb_valid && wb_warp == WW'(w);
            assign disp_w = disp_valid && disp_warp == WW'(w);

            // R5: a blocked slot can only become ready through a writeback to its warp.
            p_rise_needs_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!ready[E] && !wb_w && !ins_e) |=> !ready[E]);

            // R2: a ready slot stays ready until it is dispatched or overwritten.
            p_ready_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (ready[E] && !disp_w && !ins_e) |=> ready[E]);

            // R6: only ready slots are dispatched.
            p_disp_only_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
                disp_e |-> ready[E]);

            // R6: a dispatched slot is empty afterwards.
            p_taken_slot_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (disp_e && !ins_e) |=> !ready[E]);
        end
    end
endmodule

bind sb_warp_scoreboard sb_warp_scoreboard_chk #(
    .NUM_WARPS(NUM_WARPS), .NUM_REGS(NUM_REGS), .TRACK(TRACK), .SLOTS(SLOTS)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_warp(ins_warp), .ins_slot(ins_slot),
    .disp_valid(disp_valid), .disp_warp(disp_warp), .disp_slot(disp_slot),
    .wb_valid(wb_valid), .wb_warp(wb_warp), .ready(ready)
);

// File: tb/sb_warp_scoreboard_tb.sv
// Directed bench for sb_warp_scoreboard: one task per scenario.
module sb_warp_scoreboard_tb;
    localparam int NW = 8, NR = 128, T = 6, S = 4;
    localparam int WW = 3, SW = 2, RW = 7, NE = NW*S;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid, ins_srca_en, ins_srcb_en, ins_dst_en;
    logic [WW-1:0] ins_warp;
    logic [SW-1:0] ins_slot;
    logic [RW-1:0] ins_srca, ins_srcb, ins_dst;
    logic disp_valid;
    logic [WW-1:0] disp_warp;
    logic [SW-1:0] disp_slot;
    logic wb_valid;
    logic [WW-1:0] wb_warp;
    logic [RW-1:0] wb_reg;
    logic [NE-1:0] ready;
    int n_chk = 0, n_bad = 0;
    bit fin = 1'b0;

    sb_warp_scoreboard #(.NUM_WARPS(NW), .NUM_REGS(NR), .TRACK(T), .SLOTS(S)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_warp(ins_warp), .ins_slot(ins_slot),
        .ins_srca(ins_srca), .ins_srca_en(ins_srca_en),
        .ins_srcb(ins_srcb), .ins_srcb_en(ins_srcb_en),
        .ins_dst(ins_dst), .ins_dst_en(ins_dst_en),
        .disp_valid(disp_valid), .disp_warp(disp_warp), .disp_slot(disp_slot),
        .wb_valid(wb_valid), .wb_warp(wb_warp), .wb_reg(wb_reg),
        .ready(ready)
    );

    always #4 clk = ~clk;

    task automatic clr_in();
        ins_valid = 0; ins_warp = '0; ins_slot = '0;
        ins_srca = '0; ins_srca_en = 0; ins_srcb = '0; ins_srcb_en = 0;
        ins_dst = '0; ins_dst_en = 0;
        disp_valid = 0; disp_warp = '0; disp_slot = '0;
        wb_valid = 0; wb_warp = '0; wb_reg = '0;
    endtask

    // Apply the driven operations at one edge and sample 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
        clr_in();
    endtask

    task automatic set_ins(int w, int s, int a, bit ae, int b, bit be, int d, bit de);
        ins_valid = 1; ins_warp = WW'(w); ins_slot = SW'(s);
        ins_srca = RW'(a); ins_srca_en = ae;
        ins_srcb = RW'(b); ins_srcb_en = be;
        ins_dst = RW'(d); ins_dst_en = de;
    endtask

    task automatic set_disp(int w, int s);
        disp_valid = 1; disp_warp = WW'(w); disp_slot = SW'(s);
    endtask

    task automatic set_wb(int w, int r);
        wb_valid = 1; wb_warp = WW'(w); wb_reg = RW'(r);
    endtask

    task automatic chk_rdy(int w, int s, bit exp, string tag);
        n_chk++;
        if (ready[w*S+s] !== exp) begin
            n_bad++;
            $display("FAIL %s: ready warp %0d slot %0d actual %b expected %b",
                     tag, w, s, ready[w*S+s], exp);
        end
    endtask

    // Insert an instruction with destination d into slot 3 and dispatch it.
    task automatic issue_one(int w, int d);
        set_ins(w, 3, 0, 0, 0, 0, d, 1); tick();
        set_disp(w, 3); tick();
    endtask

    task automatic t_reset();
        clr_in();
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (ready !== '0) begin n_bad++; $display("FAIL R1: ready in reset actual %h expected 0", ready); end
        rst_n = 1;
        @(posedge clk); #1;
        n_chk++;
        if (ready !== '0) begin n_bad++; $display("FAIL R1: ready after reset actual %h expected 0", ready); end
    endtask

    task automatic t_basic_raw();
        set_ins(0, 0, 3, 1, 5, 1, 7, 1); tick();
        chk_rdy(0, 0, 1, "R2");
        set_disp(0, 0); tick();
        chk_rdy(0, 0, 0, "R6");
        set_ins(0, 1, 7, 1, 0, 0, 9, 1); tick();
        chk_rdy(0, 1, 0, "R3");
        tick();
        chk_rdy(0, 1, 0, "R3");
        set_wb(0, 7); tick();
        chk_rdy(0, 1, 1, "R5");
        set_disp(0, 1); tick();
        set_wb(0, 9); tick();
    endtask

    task automatic t_waw();
        issue_one(1, 20);
        set_ins(1, 1, 1, 1, 2, 1, 20, 1); tick();
        chk_rdy(1, 1, 0, "R4");
        set_ins(1, 2, 1, 1, 0, 0, 21, 1); tick();
        chk_rdy(1, 2, 1, "R4");
        set_wb(1, 20); tick();
        chk_rdy(1, 1, 1, "R5");
        set_disp(1, 1); tick();
        set_disp(1, 2); tick();
        set_wb(1, 20); tick();
        set_wb(1, 21); tick();
    endtask

    task automatic t_full_ooo();
        for (int d = 40; d < 45; d++) issue_one(2, d);
        set_ins(2, 0, 100, 1, 0, 0, 0, 0); tick();
        chk_rdy(2, 0, 1, "R11");
        set_disp(2, 0); tick();
        set_ins(2, 3, 0, 0, 0, 0, 45, 1); tick();
        chk_rdy(2, 3, 1, "R11");
        set_disp(2, 3); tick();
        set_ins(2, 1, 0, 0, 0, 0, 50, 1); tick();
        chk_rdy(2, 1, 0, "R7");
        set_ins(2, 2, 60, 1, 0, 0, 0, 0); tick();
        chk_rdy(2, 2, 1, "R7");
        set_wb(2, 42); tick();
        chk_rdy(2, 1, 1, "R7");
        set_ins(2, 3, 40, 1, 0, 0, 0, 0); tick();
        chk_rdy(2, 3, 0, "R13");
        set_wb(2, 40); tick();
        chk_rdy(2, 3, 1, "R13");
        set_disp(2, 1); tick();
        set_disp(2, 2); tick();
        set_disp(2, 3); tick();
        set_wb(2, 41); tick();
        set_wb(2, 43); tick();
        set_wb(2, 44); tick();
        set_wb(2, 45); tick();
        set_wb(2, 50); tick();
    endtask

    task automatic t_same_cycle();
        issue_one(3, 10);
        set_ins(3, 0, 0, 0, 0, 0, 11, 1); tick();
        chk_rdy(3, 0, 1, "R8");
        set_wb(3, 10); set_disp(3, 0); tick();
        chk_rdy(3, 0, 0, "R8");
        set_ins(3, 1, 10, 1, 0, 0, 0, 0); tick();
        chk_rdy(3, 1, 1, "R8");
        set_ins(3, 2, 11, 1, 0, 0, 0, 0); tick();
        chk_rdy(3, 2, 0, "R8");
        set_wb(3, 11); tick();
        chk_rdy(3, 2, 1, "R8");
    endtask

    task automatic t_bypass();
        issue_one(4, 30);
        set_ins(4, 0, 0, 0, 0, 0, 31, 1); tick();
        set_disp(4, 0); set_ins(4, 1, 31, 1, 0, 0, 0, 0); tick();
        chk_rdy(4, 1, 0, "R9");
        set_wb(4, 30); set_ins(4, 2, 0, 0, 30, 1, 0, 0); tick();
        chk_rdy(4, 2, 1, "R9");
        set_wb(4, 31); tick();
        chk_rdy(4, 1, 1, "R9");
    endtask

    task automatic t_reg0();
        issue_one(5, 0);
        set_ins(5, 0, 0, 1, 0, 0, 0, 0); tick();
        chk_rdy(5, 0, 0, "R10");
        set_wb(5, 0); tick();
        chk_rdy(5, 0, 1, "R10");
    endtask

    task automatic t_isolation();
        issue_one(6, 70);
        set_ins(7, 0, 70, 1, 0, 0, 70, 1); tick();
        chk_rdy(7, 0, 1, "R12");
        set_ins(6, 0, 70, 1, 0, 0, 0, 0); tick();
        chk_rdy(6, 0, 0, "R12");
        set_wb(7, 70); tick();
        chk_rdy(6, 0, 0, "R12");
        set_wb(6, 70); tick();
        chk_rdy(6, 0, 1, "R12");
    endtask

    initial begin
        t_reset();
        t_basic_raw();
        t_waw();
        t_full_ooo();
        t_same_cycle();
        t_bypass();
        t_reg0();
        t_isolation();
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule